// File: doc/BRIEF.md
# Host I/O and Memory Decode Windows

This block sits on the host side of a peripheral-bus bridge. For every I/O-port or memory access presented to it, it decides whether the bridge claims the access and names the decode that claimed it. Three fixed legacy I/O decodes are built in: the POST diagnostic port, the keyboard-controller port pair, and the configuration-index port pair. Alongside them sit a parameterized set of programmable I/O windows and a parameterized set of programmable memory windows. Each programmable window has a base and a length field that holds the length minus one. Each fixed decode and each window has its own bit in one shared enable register. An access that no fixed decode and no window claims can still be claimed by subtractive decode, which routes it to a selectable target.

Software programs the block through a simple word-addressed register port. Reads are combinational and writes take effect at the clock edge. A bulk-clear strobe returns the whole decode setup to zero in one write, but it leaves the POST-port enable as it was. Decode results appear one clock after the request.

Top module: `host_decode_win`

## Requirements
- R1: After reset every register reads zero and `dec_valid`, `dec_hit`, `dec_kind` and `dec_index` are zero.
- R2: Register reads return what was written, masked to the field width, and unused bits read zero. The register word addresses are: 0 enable, 1 global control, 16+2i I/O window i base (16 bits), 17+2i I/O window i length-minus-one (8 bits), 32+2i memory window i base (32 bits), 33+2i memory window i length-minus-one (16 bits). Any other address reads zero. In the enable register, bit 0 enables port 0x80, bit 1 enables ports 0x60/0x64, bit 2 enables ports 0x2E/0x2F, bit 8+i enables I/O window i and bit 16+i enables memory window i. In global control, bit 0 is the clear strobe and reads 0, bit 2 is the subtractive enable and bits [4:3] are the subtractive target.
- R3: An I/O access claimed by a fixed decode gives `dec_kind`=1. The index is 0 for port 0x80, 1 for ports 0x60 or 0x64, and 2 for ports 0x2E or 0x2F. Neighbouring ports such as 0x62 or 0x84 are not claimed by a fixed decode. Memory accesses never match a fixed decode.
- R4: An I/O access matches I/O window i when base ≤ addr ≤ base + length field. The compare is inclusive and has no wrap above 0xFFFF. A match gives `dec_kind`=2 and `dec_index`=i. Only `acc_addr[15:0]` is used for I/O accesses.
- R5: A memory access matches memory window i under the same inclusive rule over 32 bits, with no wrap above 0xFFFFFFFF. A match gives `dec_kind`=3 and `dec_index`=i.
- R6: A window or fixed decode whose enable bit is clear never matches, whatever its base and length.
- R7: Fixed decodes take priority over I/O windows. Among overlapping windows of one class, the lowest-numbered window wins.
- R8: I/O accesses never match memory windows, and memory accesses never match I/O windows.
- R9: When no fixed decode or window matches and the subtractive enable is set, the access is claimed with `dec_kind`=4 and `dec_index` equal to the target field. Subtractive decode has no effect on an access that a positive decode claims.
- R10: Writing global control with bit 0 set zeroes every enable bit except the port-0x80 enable, which keeps its value, and zeroes all window bases and lengths. The same write still updates the subtractive fields. A clear wins over any window write in the same cycle.
- R11: The decode outputs are registered. `dec_valid` follows `acc_valid` one clock later. In a cycle with no request, `dec_hit`, `dec_kind` and `dec_index` are zero. Misses give `dec_kind`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| acc_valid | input | 1 | Access request present |
| acc_is_io | input | 1 | 1 for an I/O-port access, 0 for a memory access |
| acc_addr | input | 32 | Access address |
| dec_valid | output | 1 | Decode result present (one clock after request) |
| dec_hit | output | 1 | Access claimed |
| dec_kind | output | 3 | 0 miss, 1 fixed, 2 I/O window, 3 memory window, 4 subtractive |
| dec_index | output | 2 | Fixed-decode number, window number or subtractive target |

## Verification
The hardest situations to reach are the ones where several decodes claim the same address. These are a fixed port sitting inside an enabled I/O window, two windows that overlap, an I/O window and a memory window with the same numeric base, and windows whose upper end would wrap past the top of the address space. The stimulus programs one layout that contains every one of these overlaps at once and then walks a table of addresses on both sides of each window edge. After that, enables are removed one at a time to expose the decode that had been shadowed. Subtractive decode is checked afterwards, and so is a bulk clear combined with a subtractive update in the same write.

// File: rtl/hdw_pkg.sv
package hdw_pkg;

   typedef enum logic [2:0] {
      KIND_NONE  = 3'd0,
      KIND_FIXED = 3'd1,
      KIND_GIO   = 3'd2,
      KIND_GMEM  = 3'd3,
      KIND_SUB   = 3'd4
   } dec_kind_e;

   // register word addresses
   localparam int ADR_ENABLE = 0;
   localparam int ADR_GCTL   = 1;
   localparam int ADR_IO0    = 16;
   localparam int ADR_MM0    = 32;
   localparam int MAX_WIN    = 8;

   // enable register layout
   localparam int EN_IO_LSB  = 8;
   localparam int EN_MM_LSB  = 16;

   // global control layout
   localparam int GC_CLR     = 0;
   localparam int GC_SUB_EN  = 2;
   localparam int GC_TGT_LSB = 3;

   // fixed legacy ports
   localparam logic [15:0] PORT_POST  = 16'h0080;
   localparam logic [15:0] PORT_KBC_A = 16'h0060;
   localparam logic [15:0] PORT_KBC_B = 16'h0064;
   localparam logic [15:0] PORT_CFG_A = 16'h002E;
   localparam logic [15:0] PORT_CFG_B = 16'h002F;
   localparam int          N_FIXED    = 3;

endpackage

// File: rtl/hdw_regs.sv
module hdw_regs
   import hdw_pkg::*;
#(
   parameter int N_IO    = 4,
   parameter int N_MMIO  = 4,
   parameter int IO_AW   = 16,
   parameter int IO_SZW  = 8,
   parameter int MEM_AW  = 32,
   parameter int MEM_SZW = 16,
   parameter int DW      = 32,
   parameter int RAW     = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_we,
   input  logic [RAW-1:0]                 reg_addr,
   input  logic [DW-1:0]                  reg_wdata,
   output logic [DW-1:0]                  reg_rdata,
   output logic [N_FIXED-1:0]             fix_en,
   output logic [N_IO-1:0]                io_en,
   output logic [N_MMIO-1:0]              mm_en,
   output logic [N_IO-1:0][IO_AW-1:0]     io_base,
   output logic [N_IO-1:0][IO_SZW-1:0]    io_size,
   output logic [N_MMIO-1:0][MEM_AW-1:0]  mm_base,
   output logic [N_MMIO-1:0][MEM_SZW-1:0] mm_size,
   output logic                           sub_en,
   output logic [1:0]                     sub_tgt
);

   logic wr_en_reg;
   logic wr_gctl;
   logic do_clr;

   assign wr_en_reg = reg_we && (reg_addr == RAW'(ADR_ENABLE));
   assign wr_gctl   = reg_we && (reg_addr == RAW'(ADR_GCTL));
   assign do_clr    = wr_gctl && reg_wdata[GC_CLR];

   // enable bitmap; bulk clear keeps only the POST port enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_en <= '0;
         io_en  <= '0;
         mm_en  <= '0;
      end else if (do_clr) begin
         fix_en <= {{(N_FIXED-1){1'b0}}, fix_en[0]};
         io_en  <= '0;
         mm_en  <= '0;
      end else if (wr_en_reg) begin
         fix_en <= reg_wdata[N_FIXED-1:0];
         io_en  <= reg_wdata[EN_IO_LSB +: N_IO];
         mm_en  <= reg_wdata[EN_MM_LSB +: N_MMIO];
      end
   end

   // subtractive controls, written by every global control write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_en  <= 1'b0;
         sub_tgt <= '0;
      end else if (wr_gctl) begin
         sub_en  <= reg_wdata[GC_SUB_EN];
         sub_tgt <= reg_wdata[GC_TGT_LSB +: 2];
      end
   end

   // generic I/O windows
   for (genvar i = 0; i < N_IO; i++) begin : g_io
      localparam int A_BASE = ADR_IO0 + 2*i;
      localparam int A_SIZE = ADR_IO0 + 2*i + 1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            io_base[i] <= '0;
            io_size[i] <= '0;
         end else if (do_clr) begin
            io_base[i] <= '0;
            io_size[i] <= '0;
         end else if (reg_we) begin
            if (reg_addr == RAW'(A_BASE)) io_base[i] <= reg_wdata[IO_AW-1:0];
            if (reg_addr == RAW'(A_SIZE)) io_size[i] <= reg_wdata[IO_SZW-1:0];
         end
      end
   end

   // generic memory windows
   for (genvar i = 0; i < N_MMIO; i++) begin : g_mm
      localparam int A_BASE = ADR_MM0 + 2*i;
      localparam int A_SIZE = ADR_MM0 + 2*i + 1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mm_base[i] <= '0;
            mm_size[i] <= '0;
         end else if (do_clr) begin
            mm_base[i] <= '0;
            mm_size[i] <= '0;
         end else if (reg_we) begin
            if (reg_addr == RAW'(A_BASE)) mm_base[i] <= reg_wdata[MEM_AW-1:0];
            if (reg_addr == RAW'(A_SIZE)) mm_size[i] <= reg_wdata[MEM_SZW-1:0];
         end
      end
   end

   // combinational read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == RAW'(ADR_ENABLE)) begin
         reg_rdata[N_FIXED-1:0]          = fix_en;
         reg_rdata[EN_IO_LSB +: N_IO]    = io_en;
         reg_rdata[EN_MM_LSB +: N_MMIO]  = mm_en;
      end
      if (reg_addr == RAW'(ADR_GCTL)) begin
         reg_rdata[GC_SUB_EN]            = sub_en;
         reg_rdata[GC_TGT_LSB +: 2]      = sub_tgt;
      end
      for (int i = 0; i < N_IO; i++) begin
         if (reg_addr == RAW'(ADR_IO0 + 2*i))     reg_rdata = DW'(io_base[i]);
         if (reg_addr == RAW'(ADR_IO0 + 2*i + 1)) reg_rdata = DW'(io_size[i]);
      end
      for (int i = 0; i < N_MMIO; i++) begin
         if (reg_addr == RAW'(ADR_MM0 + 2*i))     reg_rdata = DW'(mm_base[i]);
         if (reg_addr == RAW'(ADR_MM0 + 2*i + 1)) reg_rdata = DW'(mm_size[i]);
      end
   end

endmodule

// File: rtl/hdw_win_match.sv
module hdw_win_match #(
   parameter int N  = 4,
   parameter int AW = 16,
   parameter int SW = 8
) (
   input  logic [N-1:0][AW-1:0] base,
   input  logic [N-1:0][SW-1:0] size,
   input  logic [N-1:0]         en,
   input  logic [AW-1:0]        addr,
   output logic [N-1:0]         match
);

   if (SW > AW) begin : g_bad_sw
      $error("hdw_win_match: size field wider than address");
   end

   for (genvar i = 0; i < N; i++) begin : g_win
      logic [AW:0] last_a;
      logic        ge_lo;
      logic        le_hi;
      // one extra bit so the upper bound never wraps
      assign last_a   = {1'b0, base[i]} + (AW+1)'(size[i]);
      assign ge_lo    = addr >= base[i];
      assign le_hi    = {1'b0, addr} <= last_a;
      assign match[i] = en[i] && ge_lo && le_hi;
   end

endmodule

// File: rtl/hdw_prio.sv
module hdw_prio #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   if ((1 << IW) < N) begin : g_bad_iw
      $error("hdw_prio: index width too small");
   end

   assign any = |req;

   // lowest set bit wins
   always_comb begin
      idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/host_decode_win.sv
module host_decode_win
   import hdw_pkg::*;
#(
   parameter int N_IO    = 4,
   parameter int N_MMIO  = 4,
   parameter int IO_AW   = 16,
   parameter int IO_SZW  = 8,
   parameter int MEM_AW  = 32,
   parameter int MEM_SZW = 16,
   parameter int DW      = 32,
   parameter int RAW     = 6,
   localparam int MAXN   = (N_IO > N_MMIO) ? ((N_IO > 4) ? N_IO : 4)
                                           : ((N_MMIO > 4) ? N_MMIO : 4),
   localparam int IDX_W  = $clog2(MAXN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [RAW-1:0]   reg_addr,
   input  logic [DW-1:0]    reg_wdata,
   output logic [DW-1:0]    reg_rdata,
   input  logic             acc_valid,
   input  logic             acc_is_io,
   input  logic [MEM_AW-1:0] acc_addr,
   output logic             dec_valid,
   output logic             dec_hit,
   output logic [2:0]       dec_kind,
   output logic [IDX_W-1:0] dec_index
);

   // elaboration checks
   if (N_IO < 1 || N_IO > MAX_WIN) begin : g_bad_nio
      $error("host_decode_win: N_IO out of range");
   end
   if (N_MMIO < 1 || N_MMIO > MAX_WIN) begin : g_bad_nmm
      $error("host_decode_win: N_MMIO out of range");
   end
   if (DW != 32 || MEM_AW > DW || IO_AW != 16) begin : g_bad_w
      $error("host_decode_win: unsupported widths");
   end
   if (RAW < 6) begin : g_bad_raw
      $error("host_decode_win: register address too narrow");
   end

   logic [N_FIXED-1:0]             fix_en;
   logic [N_IO-1:0]                io_en;
   logic [N_MMIO-1:0]              mm_en;
   logic [N_IO-1:0][IO_AW-1:0]     io_base;
   logic [N_IO-1:0][IO_SZW-1:0]    io_size;
   logic [N_MMIO-1:0][MEM_AW-1:0]  mm_base;
   logic [N_MMIO-1:0][MEM_SZW-1:0] mm_size;
   logic                           sub_en;
   logic [1:0]                     sub_tgt;

   hdw_regs #(
      .N_IO(N_IO), .N_MMIO(N_MMIO), .IO_AW(IO_AW), .IO_SZW(IO_SZW),
      .MEM_AW(MEM_AW), .MEM_SZW(MEM_SZW), .DW(DW), .RAW(RAW)
   ) i_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .fix_en(fix_en), .io_en(io_en), .mm_en(mm_en),
      .io_base(io_base), .io_size(io_size),
      .mm_base(mm_base), .mm_size(mm_size),
      .sub_en(sub_en), .sub_tgt(sub_tgt)
   );

   // fixed legacy decodes
   logic [IO_AW-1:0]   io_a;
   logic [N_FIXED-1:0] fix_hit;

   assign io_a       = acc_addr[IO_AW-1:0];
   assign fix_hit[0] = fix_en[0] && (io_a == PORT_POST);
   assign fix_hit[1] = fix_en[1] && ((io_a == PORT_KBC_A) || (io_a == PORT_KBC_B));
   assign fix_hit[2] = fix_en[2] && ((io_a == PORT_CFG_A) || (io_a == PORT_CFG_B));

   // generic windows
   logic [N_IO-1:0]   io_match;
   logic [N_MMIO-1:0] mm_match;

   hdw_win_match #(.N(N_IO), .AW(IO_AW), .SW(IO_SZW)) i_io_match (
      .base(io_base), .size(io_size), .en(io_en),
      .addr(io_a), .match(io_match)
   );

   hdw_win_match #(.N(N_MMIO), .AW(MEM_AW), .SW(MEM_SZW)) i_mm_match (
      .base(mm_base), .size(mm_size), .en(mm_en),
      .addr(acc_addr), .match(mm_match)
   );

   // priority per class
   logic             fix_any, io_any, mm_any;
   logic [IDX_W-1:0] fix_idx, io_idx, mm_idx;

   hdw_prio #(.N(N_FIXED), .IW(IDX_W)) i_fix_prio (
      .req(fix_hit), .any(fix_any), .idx(fix_idx)
   );
   hdw_prio #(.N(N_IO), .IW(IDX_W)) i_io_prio (
      .req(io_match), .any(io_any), .idx(io_idx)
   );
   hdw_prio #(.N(N_MMIO), .IW(IDX_W)) i_mm_prio (
      .req(mm_match), .any(mm_any), .idx(mm_idx)
   );

   // final selection
   dec_kind_e        nx_kind;
   logic [IDX_W-1:0] nx_idx;

   always_comb begin
      nx_kind = KIND_NONE;
      nx_idx  = '0;
      if (acc_is_io && fix_any) begin
         nx_kind = KIND_FIXED;
         nx_idx  = fix_idx;
      end else if (acc_is_io && io_any) begin
         nx_kind = KIND_GIO;
         nx_idx  = io_idx;
      end else if (!acc_is_io && mm_any) begin
         nx_kind = KIND_GMEM;
         nx_idx  = mm_idx;
      end else if (sub_en) begin
         nx_kind = KIND_SUB;
         nx_idx  = IDX_W'(sub_tgt);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_hit   <= 1'b0;
         dec_kind  <= KIND_NONE;
         dec_index <= '0;
      end else begin
         dec_valid <= acc_valid;
         if (acc_valid) begin
            dec_hit   <= (nx_kind != KIND_NONE);
            dec_kind  <= nx_kind;
            dec_index <= nx_idx;
         end else begin
            dec_hit   <= 1'b0;
            dec_kind  <= KIND_NONE;
            dec_index <= '0;
         end
      end
   end

endmodule

// File: rtl/hdw_chk.sv
module hdw_chk
   import hdw_pkg::*;
#(
   parameter int N_IO   = 4,
   parameter int N_MMIO = 4,
   parameter int IDX_W  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_is_io,
   input logic [15:0]      acc_io_addr,
   input logic             wr_clr,
   input logic             dec_valid,
   input logic             dec_hit,
   input logic [2:0]       dec_kind,
   input logic [IDX_W-1:0] dec_index,
   input logic [N_FIXED-1:0] fix_en,
   input logic [N_IO-1:0]  io_en,
   input logic [N_MMIO-1:0] mm_en,
   input logic             sub_en
);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> dec_valid); // R11

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!dec_valid && !dec_hit && dec_kind == 3'd0)); // R11

   AST_POST_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_is_io && acc_io_addr == PORT_POST && fix_en[0])
      |=> (dec_hit && dec_kind == 3'd1 && dec_index == '0)); // R7

   AST_NO_EN_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_is_io && io_en == '0 && fix_en == '0 && !sub_en)
      |=> !dec_hit); // R6

   AST_MEM_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_is_io)
      |=> (dec_kind != 3'd1 && dec_kind != 3'd2)); // R8

   AST_SUB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_kind == 3'd4) |-> $past(sub_en)); // R9

   AST_CLEAR_KEEPS_POST: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (io_en == '0 && mm_en == '0 && fix_en[2:1] == 2'b00
                  && fix_en[0] == $past(fix_en[0]))); // R10

endmodule

bind host_decode_win hdw_chk #(
   .N_IO(N_IO), .N_MMIO(N_MMIO), .IDX_W(IDX_W)
) i_chk (
   .clk(clk), .rst_n(rst_n),
   .acc_valid(acc_valid), .acc_is_io(acc_is_io),
   .acc_io_addr(acc_addr[15:0]),
   .wr_clr(reg_we && (reg_addr == RAW'(hdw_pkg::ADR_GCTL)) && reg_wdata[hdw_pkg::GC_CLR]),
   .dec_valid(dec_valid), .dec_hit(dec_hit),
   .dec_kind(dec_kind), .dec_index(dec_index),
   .fix_en(fix_en), .io_en(io_en), .mm_en(mm_en), .sub_en(sub_en)
);

// File: tb/test_host_decode_win.sv
`timescale 1ns/1ps
module test_host_decode_win;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acc_valid = 1'b0;
   logic        acc_is_io = 1'b0;
   logic [31:0] acc_addr = '0;
   logic        dec_valid;
   logic        dec_hit;
   logic [2:0]  dec_kind;
   logic [1:0]  dec_index;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   host_decode_win i_host_decode_win (
      .clk(clk), .rst_n(rst_n),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .acc_valid(acc_valid), .acc_is_io(acc_is_io), .acc_addr(acc_addr),
      .dec_valid(dec_valid), .dec_hit(dec_hit),
      .dec_kind(dec_kind), .dec_index(dec_index)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         total = total + 1;
         bad   = bad + 1;
         $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   // result packed as {valid, hit, kind, index}
   task automatic acc_chk(input string req, input logic io, input logic [31:0] a,
                          input logic eh, input logic [2:0] ek, input logic [1:0] ei);
      @(negedge clk);
      acc_valid = 1'b1; acc_is_io = io; acc_addr = a;
      @(negedge clk);
      acc_valid = 1'b0;
      check(req, {25'd0, dec_valid, dec_hit, dec_kind, dec_index},
                 {25'd0, 1'b1, eh, ek, ei});
   endtask

   // {is_io, addr, hit, kind, index}
   localparam int NV = 32;
   localparam logic [38:0] VEC [0:NV-1] = '{
      {1'b1, 32'h0000_0080, 1'b1, 3'd1, 2'd0},
      {1'b1, 32'h0000_0081, 1'b1, 3'd2, 2'd2},
      {1'b1, 32'h0000_0083, 1'b1, 3'd2, 2'd2},
      {1'b1, 32'h0000_0084, 1'b0, 3'd0, 2'd0},
      {1'b1, 32'h0000_0060, 1'b1, 3'd1, 2'd1},
      {1'b1, 32'h0000_0064, 1'b1, 3'd1, 2'd1},
      {1'b1, 32'h0000_0062, 1'b0, 3'd0, 2'd0},
      {1'b1, 32'h0000_002E, 1'b1, 3'd1, 2'd2},
      {1'b1, 32'h0000_002F, 1'b1, 3'd1, 2'd2},
      {1'b1, 32'h0000_03FF, 1'b0, 3'd0, 2'd0},
      {1'b1, 32'h0000_0400, 1'b1, 3'd2, 2'd0},
      {1'b1, 32'h0000_040C, 1'b1, 3'd2, 2'd0},
      {1'b1, 32'h0000_040F, 1'b1, 3'd2, 2'd0},
      {1'b1, 32'h0000_0410, 1'b1, 3'd2, 2'd1},
      {1'b1, 32'h0000_0417, 1'b1, 3'd2, 2'd1},
      {1'b1, 32'h0000_0418, 1'b0, 3'd0, 2'd0},
      {1'b1, 32'h0000_FFFF, 1'b1, 3'd2, 2'd3},
      {1'b1, 32'h0000_FFFE, 1'b0, 3'd0, 2'd0},
      {1'b1, 32'h0000_0001, 1'b0, 3'd0, 2'd0},
      {1'b1, 32'h0001_0080, 1'b1, 3'd1, 2'd0},
      {1'b1, 32'h0000_1234, 1'b0, 3'd0, 2'd0},
      {1'b0, 32'h0000_0080, 1'b0, 3'd0, 2'd0},
      {1'b0, 32'h0000_0400, 1'b1, 3'd3, 2'd2},
      {1'b0, 32'h0000_0410, 1'b0, 3'd0, 2'd0},
      {1'b0, 32'hFED0_0000, 1'b1, 3'd3, 2'd0},
      {1'b0, 32'hFED0_0900, 1'b1, 3'd3, 2'd0},
      {1'b0, 32'hFED0_1000, 1'b1, 3'd3, 2'd1},
      {1'b0, 32'hFED1_07FF, 1'b1, 3'd3, 2'd1},
      {1'b0, 32'hFED1_0800, 1'b0, 3'd0, 2'd0},
      {1'b0, 32'hFFFF_FFFF, 1'b1, 3'd3, 2'd3},
      {1'b0, 32'hFFFF_FFEF, 1'b0, 3'd0, 2'd0},
      {1'b0, 32'h0000_00E0, 1'b0, 3'd0, 2'd0}
   };

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      check("R1 dec after reset", {28'd0, dec_valid, dec_hit, dec_kind == 3'd0, dec_index == 2'd0},
            {28'd0, 1'b0, 1'b0, 1'b1, 1'b1});
      rst_n = 1'b1;
      rd_chk("R1 enable reset", 6'd0, 32'h0);
      rd_chk("R1 gctl reset", 6'd1, 32'h0);
      rd_chk("R1 io base reset", 6'd16, 32'h0);
      rd_chk("R1 mem size reset", 6'd39, 32'h0);

      // R2: read back with field masking
      wr(6'd16, 32'hABCD_1234); rd_chk("R2 io base", 6'd16, 32'h0000_1234);
      wr(6'd17, 32'h0000_01FF); rd_chk("R2 io size", 6'd17, 32'h0000_00FF);
      wr(6'd32, 32'hDEAD_BEEF); rd_chk("R2 mem base", 6'd32, 32'hDEAD_BEEF);
      wr(6'd33, 32'h0001_2345); rd_chk("R2 mem size", 6'd33, 32'h0000_2345);
      wr(6'd0,  32'hFFFF_FFFF); rd_chk("R2 enable", 6'd0, 32'h000F_0F07);
      wr(6'd1,  32'h0000_00FE); rd_chk("R2 gctl", 6'd1, 32'h0000_001C);
      rd_chk("R2 unmapped", 6'd5, 32'h0);
      wr(6'd1,  32'h0);

      // layout with overlaps
      wr(6'd0, 32'h000F_0F07);
      wr(6'd16, 32'h0400); wr(6'd17, 32'h0F);
      wr(6'd18, 32'h0408); wr(6'd19, 32'h0F);
      wr(6'd20, 32'h0080); wr(6'd21, 32'h03);
      wr(6'd22, 32'hFFFF); wr(6'd23, 32'h03);
      wr(6'd32, 32'hFED0_0000); wr(6'd33, 32'h0FFF);
      wr(6'd34, 32'hFED0_0800); wr(6'd35, 32'hFFFF);
      wr(6'd36, 32'h0000_0400); wr(6'd37, 32'h000F);
      wr(6'd38, 32'hFFFF_FFF0); wr(6'd39, 32'h00FF);

      // R3 R4 R5 R7 R8: vector walk
      for (int v = 0; v < NV; v++) begin
         acc_chk($sformatf("R3/R4/R5/R7/R8 vec%0d", v), VEC[v][38], VEC[v][37:6],
                 VEC[v][5], VEC[v][4:2], VEC[v][1:0]);
      end

      // R11: idle cycle after a request
      @(negedge clk);
      check("R11 idle", {29'd0, dec_valid, dec_hit, dec_kind != 3'd0}, 32'h0);

      // R6: enable gating
      wr(6'd0, 32'h000F_0E07);
      acc_chk("R6 io win0 off", 1'b1, 32'h0400, 1'b0, 3'd0, 2'd0);
      acc_chk("R6 io win1 exposed", 1'b1, 32'h040C, 1'b1, 3'd2, 2'd1);
      wr(6'd0, 32'h000F_0E06);
      acc_chk("R6 post off exposes win2", 1'b1, 32'h0080, 1'b1, 3'd2, 2'd2);
      wr(6'd0, 32'h000E_0E06);
      acc_chk("R6 mem win0 off", 1'b0, 32'hFED0_0000, 1'b0, 3'd0, 2'd0);

      // R9: subtractive decode
      wr(6'd0, 32'h000F_0F07);
      wr(6'd1, 32'h0000_0014);
      acc_chk("R9 sub io", 1'b1, 32'h1234, 1'b1, 3'd4, 2'd2);
      acc_chk("R9 sub mem", 1'b0, 32'h0000_0410, 1'b1, 3'd4, 2'd2);
      acc_chk("R9 positive wins", 1'b1, 32'h0060, 1'b1, 3'd1, 2'd1);
      wr(6'd1, 32'h0000_001C);
      acc_chk("R9 target 3", 1'b1, 32'h1234, 1'b1, 3'd4, 2'd3);
      wr(6'd1, 32'h0);

      // R10: bulk clear
      wr(6'd1, 32'h0000_0001);
      rd_chk("R10 enable keeps post", 6'd0, 32'h0000_0001);
      rd_chk("R10 io base cleared", 6'd16, 32'h0);
      rd_chk("R10 mem size cleared", 6'd33, 32'h0);
      rd_chk("R10 gctl strobe reads 0", 6'd1, 32'h0);
      acc_chk("R10 post still decodes", 1'b1, 32'h0080, 1'b1, 3'd1, 2'd0);
      acc_chk("R10 kbc gone", 1'b1, 32'h0060, 1'b0, 3'd0, 2'd0);
      acc_chk("R10 io win gone", 1'b1, 32'h0400, 1'b0, 3'd0, 2'd0);
      acc_chk("R10 mem win gone", 1'b0, 32'hFED0_0000, 1'b0, 3'd0, 2'd0);
      wr(6'd0, 32'h0000_0002);
      wr(6'd1, 32'h0000_0015);
      rd_chk("R10 clear with post off", 6'd0, 32'h0);
      rd_chk("R10 sub fields updated", 6'd1, 32'h0000_0014);
      acc_chk("R10 kbc now subtractive", 1'b1, 32'h0060, 1'b1, 3'd4, 2'd2);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule